// File: doc/BRIEF.md
# Supply-Droop Alarm Register Unit

This block watches a digitized supply-voltage reading, given as a millivolt code, and raises three graded alarms when the supply sags: warning B, warning A and critical. Each alarm has its own threshold, its own comparator enable and its own debounce length, all held in one configuration byte. An alarm changes state only after the compare result has disagreed with it for a full debounce window. Short dips and short recoveries are therefore filtered out.

Every change of a debounced alarm, rising or falling, latches a pending interrupt bit. Unmasked pending bits pull an active-low interrupt line toward the host. Software clears pending bits by writing ones. Four protective output pins follow the alarms. Each pin has its own enable, polarity and sticky settings. A sticky pin holds its asserted level until software writes its release bit at a time when the alarm it follows has already gone inactive.

The register port is a simple byte-wide synchronous write port with a combinational read-back. The analog front end, the converter and the bus bridge sit outside this block.

Top module: `droop_alarm_unit`

## Requirements
- R1: After reset, every protective pin is 0, `irq_n` is 1, the mask register (address 9) reads 0x07, and the configuration, behaviour, pending, status and release registers all read 0.
- R2: Alarm levels are indexed by status bit: warning B is bit 0, warning A is bit 1 and critical is bit 2. Level i is configured by the byte at address i. In that byte, bits [2:0] hold a code c that selects a threshold of 3300 - 100*c mv, and bit 3 enables the comparator. A level's compare is true when the voltage code is strictly below its threshold. The debounced alarms read back at address 10, using the same bit positions.
- R3: When a level's comparator-enable bit is 0, its compare is false, so its alarm never asserts, and an asserted alarm falls after its debounce window.
- R4: Bits [6:4] of a configuration byte hold a value d. The debounce window N is 1 when d is 0 and 3*d-1 otherwise, so d=7 gives 20 cycles. An alarm takes the compare value on the N-th consecutive clock edge at which the compare disagrees with it. A disagreement that lasts fewer edges leaves the alarm unchanged.
- R5: Each alarm change in either direction sets the pending bit at the alarm's status position, at the same edge as the change. The pending register is at address 8. Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged.
- R6: If an alarm change and a write-one-to-clear of the same pending bit fall on the same edge, the pending bit ends up set.
- R7: `irq_n` is 0 exactly when some pending bit is set and its mask bit (address 9, same positions) is 0. Masked pending bits stay latched.
- R8: The behaviour registers are at addresses 4 to 7 and control pins 0 to 3. Pin 0 follows warning A, pin 1 follows warning B, and pins 2 and 3 both follow critical. In each behaviour register, bit 0 enables the pin, bit 1 selects active-low polarity and bit 2 selects sticky mode. A disabled pin rests at its inactive level, which equals its polarity bit.
- R9: An enabled non-sticky pin shows its alarm level after polarity, changing at the same edge as the alarm.
- R10: An enabled sticky pin asserts with its alarm and stays asserted until a 1 is written to its release bit at address 11 while its alarm is inactive. The release bits are: bit 1 for critical (pins 2 and 3), bit 2 for warning B (pin 1) and bit 3 for warning A (pin 0). A release written while the alarm is active is ignored. Reading address 11 returns the held flags at those same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| volt_mv | input | 12 | Digitized supply voltage in millivolts |
| reg_we | input | 1 | Register write strobe, taken at the clock edge |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_n | output | 1 | Active-low interrupt, low while an unmasked bit is pending |
| prot_out | output | 4 | Protective output pins |

## Verification
Two pairs of events can land on the same clock edge. In the first, a debounced alarm flips while software writes a one to clear that alarm's pending bit. The bench provokes this by changing the voltage and issuing the clear on the same edge with a one-cycle window, and it judges the result by reading the bit back as set. In the second, software writes a sticky release while the alarm is still active. The bench judges this by checking that the pin stays asserted, and then checks that the same write, repeated after the alarm falls, releases the pin.

// File: rtl/droop_pkg.sv
// Shared constants, register layouts and pin-to-level mapping for the
// supply-droop alarm unit. Assumes three alarm levels and four pins.
package droop_pkg;

    localparam int NLVL    = 3;
    localparam int NOUT    = 4;
    localparam int BASE_MV = 3300;
    localparam int STEP_MV = 100;

    // register addresses
    localparam int A_LCFG0 = 0;
    localparam int A_OCFG0 = 4;
    localparam int A_PEND  = 8;
    localparam int A_MASK  = 9;
    localparam int A_STAT  = 10;
    localparam int A_REL   = 11;

    // per-level configuration byte
    typedef struct packed {
        logic       rsvd;
        logic [2:0] db;
        logic       en;
        logic [2:0] thr;
    } lvl_cfg_t;

    // per-pin behaviour bits
    typedef struct packed {
        logic sticky;
        logic pol;
        logic en;
    } out_cfg_t;

    // alarm level that drives pin k
    function automatic int pin_level(input int k);
        return (k == 0) ? 1 : (k == 1) ? 0 : 2;
    endfunction

    // release-bit position for an alarm level
    function automatic int rel_bit(input int lvl);
        return (lvl == 2) ? 1 : (lvl == 0) ? 2 : 3;
    endfunction

endpackage

// File: rtl/droop_level.sv
// One alarm level: threshold compare plus symmetric debounce.
// Assumes the voltage code is already synchronous to clk.
module droop_level
    import droop_pkg::*;
#(
    parameter int VW      = 12,
    parameter int DB_STEP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] volt_mv,
    input  lvl_cfg_t      cfg,
    output logic          alarm,
    output logic          flip
);
    localparam int MAXN  = 7 * DB_STEP;
    localparam int CNT_W = $clog2(MAXN + 1);

    logic [VW-1:0]    thr_mv;
    logic             cond;
    logic [CNT_W-1:0] need_n;
    logic [CNT_W-1:0] cnt;

    // threshold, compare result and window length from the config byte
    always_comb begin
        thr_mv = VW'(BASE_MV - STEP_MV * int'(cfg.thr));
        cond   = cfg.en && (volt_mv < thr_mv);
        need_n = (cfg.db == 3'd0) ? CNT_W'(1) : CNT_W'(int'(cfg.db) * DB_STEP - 1);
        flip   = (cond != alarm) && ({1'b0, cnt} + 1'b1 >= {1'b0, need_n});
    end

    // count consecutive disagreeing edges and update the alarm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm <= 1'b0;
            cnt   <= '0;
        end else if (cond == alarm) begin
            cnt   <= '0;
        end else if (flip) begin
            alarm <= cond;
            cnt   <= '0;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // R4
    flip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm != $past(alarm)) |-> ($past(cond) == alarm));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(MAXN));

endmodule

// File: rtl/droop_irq.sv
// Pending/mask registers and the active-low interrupt line.
// Assumes flip pulses mark the edge at which an alarm changes.
module droop_irq
    import droop_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] flip,
    input  logic            wr_pend,
    input  logic            wr_mask,
    input  logic [NLVL-1:0] wbits,
    output logic [NLVL-1:0] pend,
    output logic [NLVL-1:0] mask,
    output logic            irq_n
);
    // latch alarm changes, clear on write-one; a new change wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~(wr_pend ? wbits : '0)) | flip;
        end
    end

    // mask register, all masked after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (wr_mask) begin
            mask <= wbits;
        end
    end

    // drive interrupt low for any unmasked pending bit
    always_comb irq_n = ~|(pend & ~mask);

    // R5
    pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & ~$past(flip)) == '0);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flip) & ~pend) == '0);

endmodule

// File: rtl/droop_output.sv
// One protective pin: enable, polarity and sticky hold with release.
// Assumes clr is a one-cycle pulse from a release-register write.
module droop_output
    import droop_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  out_cfg_t ocfg,
    input  logic     alarm,
    input  logic     clr,
    output logic     pin,
    output logic     held
);
    logic active;

    // hold while sticky; release only when alarm has gone
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else begin
            held <= ocfg.sticky & (alarm | (held & ~clr));
        end
    end

    // apply enable and polarity
    always_comb begin
        active = alarm | held;
        pin    = ocfg.en ? (active ^ ocfg.pol) : ocfg.pol;
    end

    // R10
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(held) && $past(ocfg.sticky) && !$past(clr)) |-> held);

    // R10
    active_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alarm) && $past(ocfg.sticky)) |-> held);

endmodule

// File: rtl/droop_alarm_unit.sv
// Top of the supply-droop alarm unit: register file, three alarm levels,
// interrupt logic and four protective pins. Assumes a synchronous
// single-cycle write strobe and a combinational read.
module droop_alarm_unit
    import droop_pkg::*;
#(
    parameter int VW      = 12,
    parameter int AW      = 4,
    parameter int DB_STEP = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VW-1:0]   volt_mv,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic            irq_n,
    output logic [NOUT-1:0] prot_out
);
    lvl_cfg_t        lcfg [NLVL];
    out_cfg_t        ocfg [NOUT];
    logic [NLVL-1:0] alarm, flip, pend, mask;
    logic [NOUT-1:0] held;
    logic [7:0]      rel_rd;
    logic            wr_rel;

    // configuration and behaviour register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLVL; i++) lcfg[i] <= '0;
            for (int k = 0; k < NOUT; k++) ocfg[k] <= '0;
        end else if (reg_we) begin
            for (int i = 0; i < NLVL; i++)
                if (reg_addr == AW'(A_LCFG0 + i)) lcfg[i] <= lvl_cfg_t'(reg_wdata);
            for (int k = 0; k < NOUT; k++)
                if (reg_addr == AW'(A_OCFG0 + k)) ocfg[k] <= out_cfg_t'(reg_wdata[2:0]);
        end
    end

    always_comb wr_rel = reg_we && (reg_addr == AW'(A_REL));

    genvar gi;
    generate
        for (gi = 0; gi < NLVL; gi++) begin : g_lvl
            droop_level #(.VW(VW), .DB_STEP(DB_STEP)) u_lvl (
                .clk     (clk),
                .rst_n   (rst_n),
                .volt_mv (volt_mv),
                .cfg     (lcfg[gi]),
                .alarm   (alarm[gi]),
                .flip    (flip[gi])
            );
        end
        for (gi = 0; gi < NOUT; gi++) begin : g_out
            localparam int LV = pin_level(gi);
            localparam int RB = rel_bit(LV);
            droop_output u_out (
                .clk   (clk),
                .rst_n (rst_n),
                .ocfg  (ocfg[gi]),
                .alarm (alarm[LV]),
                .clr   (wr_rel & reg_wdata[RB]),
                .pin   (prot_out[gi]),
                .held  (held[gi])
            );
        end
    endgenerate

    droop_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flip    (flip),
        .wr_pend (reg_we && (reg_addr == AW'(A_PEND))),
        .wr_mask (reg_we && (reg_addr == AW'(A_MASK))),
        .wbits   (reg_wdata[NLVL-1:0]),
        .pend    (pend),
        .mask    (mask),
        .irq_n   (irq_n)
    );

    // gather held flags into their release-bit positions
    always_comb begin
        rel_rd = '0;
        for (int k = 0; k < NOUT; k++)
            rel_rd[rel_bit(pin_level(k))] = rel_rd[rel_bit(pin_level(k))] | held[k];
    end

    // read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NLVL; i++)
            if (reg_addr == AW'(A_LCFG0 + i)) reg_rdata = lcfg[i];
        for (int k = 0; k < NOUT; k++)
            if (reg_addr == AW'(A_OCFG0 + k)) reg_rdata = {5'd0, ocfg[k]};
        if (reg_addr == AW'(A_PEND)) reg_rdata = {5'd0, pend};
        if (reg_addr == AW'(A_MASK)) reg_rdata = {5'd0, mask};
        if (reg_addr == AW'(A_STAT)) reg_rdata = {5'd0, alarm};
        if (reg_addr == AW'(A_REL))  reg_rdata = rel_rd;
    end

endmodule

// File: tb/droop_alarm_unit_test.sv
`timescale 1ns/1ps
module droop_alarm_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] volt_mv = 12'd3400;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        irq_n;
    logic [3:0]  prot_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    droop_alarm_unit uut (
        .clk(clk), .rst_n(rst_n), .volt_mv(volt_mv), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n), .prot_out(prot_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = 4'(a);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        int nwin;
        int thr;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        check("R1 pins", int'(prot_out), 0);
        check("R1 irq_n", int'(irq_n), 1);
        rd(9, v);  check("R1 mask", v, 7);
        rd(8, v);  check("R1 pend", v, 0);
        rd(10, v); check("R1 status", v, 0);
        rd(11, v); check("R1 release", v, 0);
        for (int a = 0; a < 8; a++) begin
            if (a != 3) begin rd(a, v); check("R1 cfg", v, 0); end
        end

        // R2 threshold sweep, window 1
        for (int lvl = 0; lvl < 3; lvl++) begin
            volt_mv = 12'd3400;
            for (int c = 0; c < 8; c++) begin
                thr = 3300 - 100 * c;
                wr(lvl, 8'h08 | c);
                volt_mv = 12'(thr - 1);
                tick(1);
                rd(10, v); check("R2 below threshold", v, 1 << lvl);
                volt_mv = 12'(thr);
                tick(1);
                rd(10, v); check("R2 at threshold", v, 0);
            end
            wr(lvl, 0);
        end

        // R3 comparator disabled
        volt_mv = 12'd2000;
        wr(2, 8'h00);
        tick(3);
        rd(10, v); check("R3 disabled no alarm", v, 0);
        wr(2, 8'h08);
        tick(1);
        rd(10, v); check("R3 enabled alarm", v, 4);
        wr(2, 8'h00);
        tick(1);
        rd(10, v); check("R3 disable drops alarm", v, 0);
        volt_mv = 12'd3400;

        // R4 debounce windows in both directions
        for (int d = 0; d < 8; d++) begin
            nwin = (d == 0) ? 1 : 3 * d - 1;
            wr(2, (d << 4) | 8'h08);
            volt_mv = 12'd3000;
            if (nwin > 1) begin
                tick(nwin - 1);
                rd(10, v); check("R4 rise early", v, 0);
                tick(1);
            end else tick(1);
            rd(10, v); check("R4 rise on time", v, 4);
            volt_mv = 12'd3400;
            if (nwin > 1) begin
                tick(nwin - 1);
                rd(10, v); check("R4 fall early", v, 4);
                tick(1);
            end else tick(1);
            rd(10, v); check("R4 fall on time", v, 0);
        end
        // R4 short dip filtered (window 11)
        wr(2, 8'h48);
        volt_mv = 12'd3000;
        tick(10);
        volt_mv = 12'd3400;
        tick(15);
        rd(10, v); check("R4 short dip ignored", v, 0);
        wr(2, 0);

        // R5 / R7 pending and interrupt line
        wr(8, 7);
        rd(8, v); check("R5 pend cleared", v, 0);
        wr(9, 0);
        check("R7 irq idle", int'(irq_n), 1);
        wr(1, 8'h08);
        volt_mv = 12'd3000;
        tick(1);
        rd(8, v); check("R5 pend on rise", v, 2);
        check("R7 irq low", int'(irq_n), 0);
        wr(8, 1);
        rd(8, v); check("R5 other bit write keeps", v, 2);
        wr(8, 2);
        rd(8, v); check("R5 w1c", v, 0);
        check("R7 irq released", int'(irq_n), 1);
        volt_mv = 12'd3400;
        tick(1);
        rd(8, v); check("R5 pend on fall", v, 2);
        wr(8, 2);
        wr(9, 2);
        volt_mv = 12'd3000;
        tick(1);
        rd(8, v); check("R7 masked still latched", v, 2);
        check("R7 masked irq high", int'(irq_n), 1);
        wr(9, 0);
        check("R7 unmask irq low", int'(irq_n), 0);
        wr(8, 2);
        volt_mv = 12'd3400;
        tick(1);
        wr(8, 7);

        // R6 change and clear on the same edge
        @(negedge clk);
        volt_mv = 12'd3000;
        reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 8'h02;
        @(negedge clk);
        reg_we = 1'b0;
        rd(8, v); check("R6 set wins over clear", v, 2);
        volt_mv = 12'd3400;
        tick(1);
        wr(8, 7);
        wr(9, 7);

        // R8 / R9 / R10 protective pins
        wr(0, 8'h0F); wr(1, 8'h08); wr(2, 8'h0B);
        wr(4, 8'h02);
        check("R8 disabled rests at polarity", int'(prot_out), 4'b0001);
        wr(4, 8'h03);
        check("R8 enabled active-low idle", int'(prot_out), 4'b0001);
        volt_mv = 12'd3200;
        tick(1);
        check("R9 follows assert", int'(prot_out), 4'b0000);
        volt_mv = 12'd3400;
        tick(1);
        check("R9 follows release", int'(prot_out), 4'b0001);
        wr(5, 8'h01); wr(6, 8'h05); wr(7, 8'h07);
        check("R8 idle mix", int'(prot_out), 4'b1001);
        volt_mv = 12'd2900;
        tick(1);
        check("R8 crit and warnA", int'(prot_out), 4'b0100);
        volt_mv = 12'd2500;
        tick(1);
        check("R9 warnB pin", int'(prot_out), 4'b0110);
        volt_mv = 12'd3400;
        tick(1);
        check("R10 sticky held", int'(prot_out), 4'b0101);
        rd(11, v); check("R10 release readback", v, 2);
        wr(11, 8'h0C);
        check("R10 other release bits", int'(prot_out), 4'b0101);
        wr(11, 8'h02);
        check("R10 released", int'(prot_out), 4'b1001);
        volt_mv = 12'd2900;
        tick(1);
        check("R10 reassert", int'(prot_out), 4'b0100);
        wr(11, 8'h02);
        check("R10 release while active ignored", int'(prot_out), 4'b0100);
        volt_mv = 12'd3400;
        tick(1);
        check("R10 held after fall", int'(prot_out), 4'b0101);
        wr(11, 8'h02);
        check("R10 released again", int'(prot_out), 4'b1001);
        rd(11, v); check("R10 readback cleared", v, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule